// File: doc/BRIEF.md
# Indexed IDE Controller Configuration Port

This block holds the byte-wide configuration registers of a dual-channel IDE controller. The host reaches them through two byte locations on a simple I/O bus. A write to the index location picks one register. Reads and writes at the data location then act on that register. The index stays latched, so the host can make any number of data accesses after a single index write.

The register set has a read-only identity byte, a control byte, a command-block timing byte, three address-setup timing bytes, three read/write timing bytes, a prefetch burst-size byte and a free scratch byte. The identity byte carries the device revision and a bit that reports which of two base addresses the port is strapped to. The scratch byte lets software test that the port is present.

The block drives the decoded fields to the rest of the controller:
- the read-ahead disable for each of four drives, taken from two different registers;
- the secondary-channel enable;
- the address-setup codes;
- the active and recovery nibbles;
- the command timing byte;
- the burst byte.

Top module: `idecfg_port`

## Requirements
- R1: A write at bus offset 0 latches an 8-bit index, and that index stays in use until the next such write. A read strobe at bus offset 4 loads the selected register value onto `bus_rdata` at the next clock edge. `bus_rdata` holds its value in every cycle that has no such read. Strobes at any other offset have no effect.
- R2: Index 0x50 reads as follows: bits 1:0 hold the nonzero revision parameter, bit 5 equals `strap_low_base`, and every other bit is 0. Writes to index 0x50 change nothing.
- R3: Index 0x51 is a read/write control byte. Bit 6 drives `ra_dis[0]`, bit 7 drives `ra_dis[1]` and bit 3 drives `chan2_en`.
- R4: Index 0x57 is read/write. Bit 2 drives `ra_dis[2]`, bit 3 drives `ra_dis[3]`, and bits 7:6 drive `setup_code[5:4]`.
- R5: Indices 0x53 and 0x55 are read/write, and their bits 7:6 drive `setup_code[1:0]` and `setup_code[3:2]`. Indices 0x54, 0x56 and 0x58 are read/write timing bytes for slots 0, 1 and 2. For slot k, the high nibble drives `act_cnt[4k+3:4k]` and the low nibble drives `rec_cnt[4k+3:4k]`.
- R6: Index 0x52 is read/write and drives `cmd_tim`. Index 0x59 is read/write and drives `burst_sel`.
- R7: Index 0x5B is a scratch byte. It reads back exactly the last value written to it.
- R8: Any index outside 0x50 to 0x59 and 0x5B reads as 0x00. A write to such an index changes no register and no output.
- R9: After reset the registers hold these values:
  - index 0x00;
  - control, command, address-setup, read/write timing and scratch registers 0x00;
  - burst register 0x40;
  - `bus_rdata` 0x00.
- R10: A data write followed by a data read at the same latched index, with no index write between them, returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_low_base | input | 1 | Set when the port is decoded at the lower base address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_off | input | 3 | Offset within the port: 0 for index, 4 for data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ra_dis | output | 4 | Per-drive read-ahead disables |
| chan2_en | output | 1 | Secondary channel enable |
| cmd_tim | output | 8 | Command-block timing byte |
| setup_code | output | 6 | Address-setup codes, two bits per timing slot |
| act_cnt | output | 12 | Active-count nibbles, one per timing slot |
| rec_cnt | output | 12 | Recovery-count nibbles, one per timing slot |
| burst_sel | output | 8 | Prefetch burst-size byte |

## Verification
The bench builds the block with the revision parameter set to 3, so both revision bits read as ones. The offsets keep their defaults of 0 and 4. With revision 3, a stuck-at-zero fault on either revision bit shows up in the identity byte.

The bench drives `strap_low_base` both high and low, so bit 5 is seen in both states. The random index draws cover the whole window from 0x4E to 0x5D. That window includes the gap at 0x5A and the indices on either side of the implemented set, where decode-boundary errors would appear.

// File: rtl/idecfg_pkg.sv
package idecfg_pkg;
  localparam int NSLOT  = 11;
  localparam int SLOT_W = 4;
  localparam int NTIME  = 3;

  localparam int SL_CFG  = 0;
  localparam int SL_CTRL = 1;
  localparam int SL_CMD  = 2;
  localparam int SL_ART0 = 3;
  localparam int SL_DRW0 = 4;
  localparam int SL_ART23 = 7;
  localparam int SL_BRST = 9;
  localparam int SL_SCR  = 10;

  localparam logic [7:0] IDX_FIRST = 8'h50;
  localparam logic [7:0] IDX_LAST  = 8'h59;
  localparam logic [7:0] IDX_SCR   = 8'h5B;

  // {hit, slot}
  function automatic logic [SLOT_W:0] slot_lookup(input logic [7:0] idx);
    logic [7:0] rel;
    rel = idx - IDX_FIRST;
    if (idx >= IDX_FIRST && idx <= IDX_LAST) return {1'b1, rel[SLOT_W-1:0]};
    else if (idx == IDX_SCR) return {1'b1, SLOT_W'(SL_SCR)};
    else return '0;
  endfunction

  function automatic logic [7:0] reset_value(input int slot);
    return (slot == SL_BRST) ? 8'h40 : 8'h00;
  endfunction

  function automatic logic [7:0] ident_byte(input logic [1:0] rev, input logic strap);
    return {2'b00, strap, 3'b000, rev};
  endfunction
endpackage

// File: rtl/idecfg_decode.sv
module idecfg_decode
  import idecfg_pkg::*;
(
  input  logic [7:0]        idx,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W:0] res;
  assign res  = slot_lookup(idx);
  assign hit  = res[SLOT_W];
  assign slot = res[SLOT_W-1:0];
endmodule

// File: rtl/idecfg_regs.sv
module idecfg_regs
  import idecfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [7:0]          wdata,
  input  logic [7:0]          ident,
  output logic [NSLOT*8-1:0]  q_flat
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == SL_CFG) begin : g_ro
      assign q_flat[s*8 +: 8] = ident;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_value(s);
        else if (wr_en && wr_slot == SLOT_W'(s)) q <= wdata;
      end
      assign q_flat[s*8 +: 8] = q;
    end
  end
endmodule

// File: rtl/idecfg_fields.sv
module idecfg_fields
  import idecfg_pkg::*;
(
  input  logic [NSLOT*8-1:0] q_flat,
  output logic [3:0]         ra_dis,
  output logic               chan2_en,
  output logic [7:0]         cmd_tim,
  output logic [2*NTIME-1:0] setup_code,
  output logic [4*NTIME-1:0] act_cnt,
  output logic [4*NTIME-1:0] rec_cnt,
  output logic [7:0]         burst_sel
);
  logic [7:0] ctrl_b, art23_b;
  assign ctrl_b  = q_flat[SL_CTRL*8 +: 8];
  assign art23_b = q_flat[SL_ART23*8 +: 8];

  assign ra_dis    = {art23_b[3], art23_b[2], ctrl_b[7], ctrl_b[6]};
  assign chan2_en  = ctrl_b[3];
  assign cmd_tim   = q_flat[SL_CMD*8 +: 8];
  assign burst_sel = q_flat[SL_BRST*8 +: 8];

  for (genvar k = 0; k < NTIME; k++) begin : g_time
    localparam int ART = SL_ART0 + 2*k;
    localparam int DRW = SL_DRW0 + 2*k;
    assign setup_code[2*k +: 2] = q_flat[ART*8+6 +: 2];
    assign act_cnt[4*k +: 4]    = q_flat[DRW*8+4 +: 4];
    assign rec_cnt[4*k +: 4]    = q_flat[DRW*8 +: 4];
  end

  logic unused_fields;
  assign unused_fields = ^{q_flat[SL_CFG*8 +: 8], q_flat[SL_SCR*8 +: 8], ctrl_b[5:4],
                           ctrl_b[2:0], art23_b[5:4], art23_b[1:0],
                           q_flat[SL_ART0*8 +: 6], q_flat[(SL_ART0+2)*8 +: 6]};
endmodule

// File: rtl/idecfg_port.sv
module idecfg_port
  import idecfg_pkg::*;
#(
  parameter logic [1:0] REV      = 2'b01,
  parameter logic [2:0] IDX_OFF  = 3'd0,
  parameter logic [2:0] DATA_OFF = 3'd4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_low_base,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [2:0]           bus_off,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [3:0]           ra_dis,
  output logic                 chan2_en,
  output logic [7:0]           cmd_tim,
  output logic [2*NTIME-1:0]   setup_code,
  output logic [4*NTIME-1:0]   act_cnt,
  output logic [4*NTIME-1:0]   rec_cnt,
  output logic [7:0]           burst_sel
);
  // named bus events
  logic idx_wr_fire, data_wr_fire, data_rd_fire;
  assign idx_wr_fire  = bus_wr && (bus_off == IDX_OFF);
  assign data_wr_fire = bus_wr && (bus_off == DATA_OFF);
  assign data_rd_fire = bus_rd && (bus_off == DATA_OFF);

  logic [7:0] idx_q;
  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 8'h00;
    else if (idx_wr_fire) idx_q <= bus_wdata;
  end

  logic              dec_hit;
  logic [SLOT_W-1:0] dec_slot;
  idecfg_decode u_dec (.idx(idx_q), .hit(dec_hit), .slot(dec_slot));

  logic [NSLOT*8-1:0] q_flat;
  logic               reg_wr_en;
  assign reg_wr_en = data_wr_fire && dec_hit;

  idecfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_slot(dec_slot),
    .wdata(bus_wdata), .ident(ident_byte(REV, strap_low_base)), .q_flat(q_flat)
  );

  logic [7:0] rd_val;
  always_comb begin
    rd_val = 8'h00;
    for (int s = 0; s < NSLOT; s++)
      if (dec_hit && dec_slot == SLOT_W'(s)) rd_val = q_flat[s*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else if (data_rd_fire) bus_rdata <= rd_val;
  end

  idecfg_fields u_fields (
    .q_flat(q_flat), .ra_dis(ra_dis), .chan2_en(chan2_en), .cmd_tim(cmd_tim),
    .setup_code(setup_code), .act_cnt(act_cnt), .rec_cnt(rec_cnt), .burst_sel(burst_sel)
  );
endmodule

// File: rtl/idecfg_port_chk.sv
module idecfg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strap_low_base,
  input logic        data_rd_fire,
  input logic        data_wr_fire,
  input logic        dec_hit,
  input logic [7:0]  idx_q,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [3:0]  ra_dis,
  input logic        chan2_en,
  input logic [7:0]  cmd_tim,
  input logic [7:0]  burst_sel
);
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd_fire |=> $stable(bus_rdata));

  a_r2_ident_read: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_fire && idx_q == 8'h50 && $stable(strap_low_base))
      |=> (bus_rdata[1:0] != 2'b00 && bus_rdata[5] == $past(strap_low_base)
           && bus_rdata[7:6] == 2'b00 && bus_rdata[4:2] == 3'b000));

  a_r3_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_fire && idx_q == 8'h51)
      |=> (ra_dis[1:0] == $past(bus_wdata[7:6]) && chan2_en == $past(bus_wdata[3])));

  a_r6_burst_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_fire && idx_q == 8'h59) |=> burst_sel == $past(bus_wdata));

  a_r8_unimpl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_fire && !dec_hit) |=> bus_rdata == 8'h00);

  a_r8_unimpl_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_fire && !dec_hit)
      |=> ($stable(ra_dis) && $stable(chan2_en) && $stable(cmd_tim) && $stable(burst_sel)));
endmodule

bind idecfg_port idecfg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_low_base(strap_low_base),
  .data_rd_fire(data_rd_fire), .data_wr_fire(data_wr_fire), .dec_hit(dec_hit),
  .idx_q(idx_q), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ra_dis(ra_dis),
  .chan2_en(chan2_en), .cmd_tim(cmd_tim), .burst_sel(burst_sel)
);

// File: tb/sim_idecfg_port.sv
module sim_idecfg_port;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] TB_REV = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] off = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] ra_dis;
  logic chan2_en;
  logic [7:0] cmd_tim, burst_sel;
  logic [5:0] setup_code;
  logic [11:0] act_cnt, rec_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  idecfg_port #(.REV(TB_REV)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_low_base(strap), .bus_wr(wr), .bus_rd(rd),
    .bus_off(off), .bus_wdata(wdata), .bus_rdata(rdata), .ra_dis(ra_dis),
    .chan2_en(chan2_en), .cmd_tim(cmd_tim), .setup_code(setup_code),
    .act_cnt(act_cnt), .rec_cnt(rec_cnt), .burst_sel(burst_sel)
  );

  function automatic bit implemented(input logic [7:0] i);
    return (i >= 8'h50 && i <= 8'h59) || i == 8'h5B;
  endfunction

  function automatic logic [7:0] expect_read(input logic [7:0] i);
    if (i == 8'h50) return {2'b00, strap, 3'b000, TB_REV};
    if (implemented(i)) return mdl[i];
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; off = o; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] o);
    @(negedge clk); rd = 1'b1; off = o;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] i, input logic [7:0] d);
    bus_write(3'd0, i);
    bus_write(3'd4, d);
    if (implemented(i) && i != 8'h50) mdl[i] = d;
  endtask

  task automatic reg_read_check(input string req, input logic [7:0] i);
    bus_write(3'd0, i);
    bus_read(3'd4);
    check(req, rdata, expect_read(i));
  endtask

  task automatic check_fields(input string req);
    check({req, " ra_dis"}, ra_dis, {mdl[8'h57][3], mdl[8'h57][2], mdl[8'h51][7], mdl[8'h51][6]});
    check({req, " chan2"}, chan2_en, mdl[8'h51][3]);
    check({req, " cmd"}, cmd_tim, mdl[8'h52]);
    check({req, " burst"}, burst_sel, mdl[8'h59]);
    check({req, " setup"}, setup_code, {mdl[8'h57][7:6], mdl[8'h55][7:6], mdl[8'h53][7:6]});
    check({req, " act"}, act_cnt, {mdl[8'h58][7:4], mdl[8'h56][7:4], mdl[8'h54][7:4]});
    check({req, " rec"}, rec_cnt, {mdl[8'h58][3:0], mdl[8'h56][3:0], mdl[8'h54][3:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    foreach (mdl[i]) mdl[i] = 8'h00;
    mdl[8'h59] = 8'h40;
    repeat (3) @(negedge clk);
    // R9: reset values seen at the ports while reset is held
    check("R9 rdata", rdata, 8'h00);
    check_fields("R9");
    rst_n = 1'b1;
    for (int i = 8'h50; i <= 8'h5B; i++) reg_read_check("R9 read", 8'(i));

    // R2: identity byte, both strap states, writes ignored
    strap = 1'b1;
    reg_read_check("R2 strap1", 8'h50);
    reg_write(8'h50, 8'hFF);
    reg_read_check("R2 write ignored", 8'h50);
    strap = 1'b0;
    reg_read_check("R2 strap0", 8'h50);

    // R3, R4, R5, R6: directed field placement
    reg_write(8'h51, 8'h48); check_fields("R3 ctrl");
    reg_write(8'h51, 8'h80); check_fields("R3 ctrl2");
    reg_write(8'h57, 8'hC4); check_fields("R4 art23");
    reg_write(8'h57, 8'h08); check_fields("R4 art23b");
    reg_write(8'h53, 8'h80); reg_write(8'h55, 8'h40); check_fields("R5 setup");
    reg_write(8'h54, 8'hA5); reg_write(8'h56, 8'h3C); reg_write(8'h58, 8'hF0);
    check_fields("R5 drw");
    reg_write(8'h52, 8'h11); reg_write(8'h59, 8'h00); check_fields("R6");

    // R7: scratch presence pattern
    reg_write(8'h5B, 8'hBD); reg_read_check("R7 scratch", 8'h5B);
    reg_write(8'h5B, 8'h00); reg_read_check("R7 scratch clear", 8'h5B);

    // R8: unimplemented indices
    reg_write(8'h5A, 8'hFF); check_fields("R8 write 5A");
    reg_read_check("R8 read 5A", 8'h5A);
    reg_write(8'h4F, 8'hFF); reg_read_check("R8 read 4F", 8'h4F);
    reg_write(8'hFF, 8'h77); reg_read_check("R8 read FF", 8'hFF);
    for (int i = 8'h50; i <= 8'h5B; i++) reg_read_check("R8 no side effect", 8'(i));

    // R10 and R1: latched index reused, hold, stray offsets
    bus_write(3'd0, 8'h56);
    bus_write(3'd4, 8'h69); mdl[8'h56] = 8'h69;
    bus_read(3'd4); check("R10 same index", rdata, 8'h69);
    bus_read(3'd4); check("R10 repeat read", rdata, 8'h69);
    bus_write(3'd2, 8'h51);
    bus_write(3'd4, 8'h00); mdl[8'h56] = 8'h00;
    check("R1 rdata hold", rdata, 8'h69);
    bus_read(3'd6); check("R1 stray read offset", rdata, 8'h69);
    bus_read(3'd4); check("R1 stray index offset", rdata, 8'h00);
    check_fields("R1");

    // Random mix: R1 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 400; n++) begin
      logic [7:0] i, d;
      i = 8'h4E + 8'($urandom % 16);
      d = 8'($urandom);
      if (n % 37 == 0) strap = ~strap;
      if ($urandom % 2) begin
        reg_write(i, d);
        check_fields("R3-R6 random fields");
      end else begin
        reg_read_check("R1 R8 random read", i);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule